// File: doc/BRIEF.md
# Integer Multiply Unit

This block computes 32 by 32 bit integer products for the four multiply flavours of a RISC-V style core. A two-bit operation code picks what comes back. It can be the lower word of the product, or the upper word with the operands read as signed/signed, signed/unsigned or unsigned/unsigned. The surrounding pipeline pulses a start strobe with both operands while the unit is idle. A fixed number of cycles later, a one-cycle completion pulse marks the result word as ready.

Each operand is widened by one bit before the multiply. The extra bit is a copy of the sign or a zero, as the operation requires, and a single signed multiplier then serves every flavour. The most negative operand therefore needs no special case. Software that needs a full 64-bit product issues an upper-word operation and a lower-word operation on the same operands, then joins the two answers.

Top module: `imul32`

## Requirements
- R1: Operation code 2'b00 returns bits 31:0 of the product. Operand signedness does not affect this result.
- R2: Operation code 2'b01 returns bits 63:32 of the product, with both operands read as two's complement.
- R3: Operation code 2'b10 returns bits 63:32 of the product, with the first operand read as two's complement and the second as unsigned.
- R4: Operation code 2'b11 returns bits 63:32 of the product, with both operands read as unsigned.
- R5: A start that is accepted at clock edge k raises `done_o` for exactly one cycle, right after edge k+LAT (LAT defaults to 3). The result appears in the same cycle.
- R6: A start that arrives while `busy_o` is high is ignored. It causes no extra completion pulse and does not change the pending result.
- R7: `result_o` keeps its value between completion pulses.
- R8: While `rst` is high, the unit returns to idle: `busy_o` is 0, `done_o` is 0 and `result_o` is 0.
- R9: `busy_o` is high from the edge that accepts a start until the edge that raises `done_o`. A new start may be accepted in the same cycle that `done_o` is high.
- R10: The most negative operand 0x80000000 gives exact results. Upper signed/signed of 0x80000000 by 0x80000000 is 0x40000000. Upper signed/unsigned of 0x80000000 by 0xFFFFFFFF is 0x80000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe, taken only while idle |
| op_i | input | 2 | Operation code: 00 low, 01 high s/s, 10 high s/u, 11 high u/u |
| src_a_i | input | 32 | First operand |
| src_b_i | input | 32 | Second operand |
| busy_o | output | 1 | A multiply is in flight |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Selected product word |

## Verification
The bench drives operands that expose wrong sign handling: 0x80000000, all ones, and mixed signs. A unit that zero-extends where it should sign-extend gives wrong upper words for these, while its lower words still look correct. It also fires starts into a busy unit. A unit that accepts them would produce a second completion, or would overwrite the pending operands. Back-to-back issues placed in the completion cycle catch a counter that is off by one, which would show up as a late or missing pulse. Each result's arrival cycle is also checked against the fixed latency.

// File: rtl/imul_pkg.sv
package imul_pkg;

  typedef enum logic [1:0] {
    OP_LO    = 2'b00,
    OP_HI_SS = 2'b01,
    OP_HI_SU = 2'b10,
    OP_HI_UU = 2'b11
  } mul_op_e;

endpackage

// File: rtl/imul_ext.sv
module imul_ext
  import imul_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter bit IS_FIRST = 1'b1
) (
  input  mul_op_e           op_i,
  input  logic [XLEN-1:0]   src_i,
  output logic [XLEN:0]     ext_o
);

  logic use_sign;

  generate
    if (IS_FIRST) begin : g_first
      // first operand is signed for every flavour except u/u
      assign use_sign = (op_i != OP_HI_UU);
    end else begin : g_second
      // second operand is signed only for s/s
      assign use_sign = (op_i == OP_HI_SS);
    end
  endgenerate

  assign ext_o = {use_sign & src_i[XLEN-1], src_i};

endmodule

// File: rtl/imul_seq.sv
module imul_seq #(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic accept_o,
  output logic fin_o,
  output logic busy_o
);

  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt_q;

  assign busy_o   = (cnt_q != '0);
  assign accept_o = start_i && !busy_o;
  assign fin_o    = (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (accept_o) begin
      cnt_q <= CW'(LAT);
    end else if (busy_o) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

endmodule

// File: rtl/imul_core.sv
module imul_core
  import imul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic            fin_i,
  input  logic            busy_i,
  input  logic            start_i,
  input  mul_op_e         op_i,
  input  logic [XLEN:0]   a_ext_i,
  input  logic [XLEN:0]   b_ext_i,
  output logic [XLEN-1:0] result_o
);

  localparam int PW = 2 * XLEN;

  logic [XLEN:0]   a_q, b_q;
  mul_op_e         op_q;
  logic [PW-1:0]   prod;

  // signed multiply of widened operands; the low PW bits are exact
  function automatic logic [PW-1:0] wide_mul(input logic [XLEN:0] a,
                                             input logic [XLEN:0] b);
    logic signed [PW-1:0] sa, sb;
    sa = PW'($signed(a));
    sb = PW'($signed(b));
    return sa * sb;
  endfunction

  function automatic logic [XLEN-1:0] pick_word(input mul_op_e op,
                                                input logic [PW-1:0] p);
    return (op == OP_LO) ? p[XLEN-1:0] : p[PW-1:XLEN];
  endfunction

  assign prod = wide_mul(a_q, b_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q  <= '0;
      b_q  <= '0;
      op_q <= OP_LO;
    end else if (load_i) begin
      a_q  <= a_ext_i;
      b_q  <= b_ext_i;
      op_q <= op_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
    end else if (fin_i) begin
      result_o <= pick_word(op_q, prod);
    end
  end

  // R6: a start arriving while busy leaves the captured operands untouched
  a_r6_operands_held: assert property (@(posedge clk) disable iff (rst)
    (busy_i && start_i) |=> ($stable(a_q) && $stable(b_q) && $stable(op_q)));

  // R7: the result word changes only on a finishing cycle
  a_r7_result_hold: assert property (@(posedge clk) disable iff (rst)
    !fin_i |=> $stable(result_o));

endmodule

// File: rtl/imul32.sv
module imul32
  import imul_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int LAT  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [1:0]      op_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [XLEN-1:0] result_o
);

  mul_op_e       op_sel;
  logic [XLEN:0] a_ext, b_ext;
  logic          accept, fin;

  assign op_sel = mul_op_e'(op_i);

  imul_ext #(.XLEN(XLEN), .IS_FIRST(1'b1)) ext_a_i (
    .op_i(op_sel), .src_i(src_a_i), .ext_o(a_ext));

  imul_ext #(.XLEN(XLEN), .IS_FIRST(1'b0)) ext_b_i (
    .op_i(op_sel), .src_i(src_b_i), .ext_o(b_ext));

  imul_seq #(.LAT(LAT)) seq_i (
    .clk(clk), .rst(rst), .start_i(start_i),
    .accept_o(accept), .fin_o(fin), .busy_o(busy_o));

  imul_core #(.XLEN(XLEN)) core_i (
    .clk(clk), .rst(rst), .load_i(accept), .fin_i(fin),
    .busy_i(busy_o), .start_i(start_i), .op_i(op_sel),
    .a_ext_i(a_ext), .b_ext_i(b_ext), .result_o(result_o));

  always_ff @(posedge clk) begin
    if (rst) done_o <= 1'b0;
    else     done_o <= fin;
  end

  // R5: the last count cycle is followed by the completion pulse
  a_r5_fin_then_done: assert property (@(posedge clk) disable iff (rst)
    fin |=> done_o);

  // R5: completion lasts a single cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R9: an accepted start makes the unit busy on the next cycle
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy_o);

  // R8: reset leaves the unit idle with a cleared result
  a_r8_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy_o && !done_o && result_o == '0));

endmodule

// File: tb/imul32_tb_top.sv
module imul32_tb_top;

  localparam int LAT = 3;

  typedef struct {
    logic [31:0] val;
    int          due;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [31:0] src_a_i = '0;
  logic [31:0] src_b_i = '0;
  logic        busy_o, done_o;
  logic [31:0] result_o;

  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  exp_t sb_q[$];
  logic [31:0] last_res = '0;
  bit   have_last = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  imul32 #(.XLEN(32), .LAT(LAT)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o));

  function automatic logic [31:0] ref_word(input logic [1:0] op,
                                           input logic [31:0] a,
                                           input logic [31:0] b);
    longint sa, sb, ps;
    logic [63:0] ua, ub, pu;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = {32'h0, a};
    ub = {32'h0, b};
    case (op)
      2'b00: begin pu = ua * ub; return pu[31:0]; end
      2'b01: begin ps = sa * sb; return ps[63:32]; end
      2'b10: begin ps = sa * longint'(ub); return ps[63:32]; end
      default: begin pu = ua * ub; return pu[63:32]; end
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [31:0] a,
                       input logic [31:0] b, input string tag);
    exp_t e;
    @(negedge clk);
    while (busy_o) @(negedge clk);
    e.val = ref_word(op, a, b);
    e.due = cyc + 1 + LAT;
    e.tag = tag;
    sb_q.push_back(e);
    start_i = 1'b1; op_i = op; src_a_i = a; src_b_i = b;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // monitor: pops the scoreboard on each completion
  always @(negedge clk) begin
    if (!rst) begin
      if (done_o) begin
        if (sb_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R6 actual=unexpected_done expected=no_done");
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(e.tag, result_o, e.val);
          check("R5 latency", 32'(cyc), 32'(e.due));
        end
        last_res  = result_o;
        have_last = 1'b1;
      end else if (have_last) begin
        check("R7 hold", result_o, last_res);
      end
    end
  end

  task automatic run_all();
    logic [31:0] a, b;
    repeat (3) @(negedge clk);
    // R8 reset values
    check("R8 busy", 32'(busy_o), 32'd0);
    check("R8 done", 32'(done_o), 32'd0);
    check("R8 result", result_o, 32'd0);
    rst = 1'b0;

    issue(2'b00, 32'd7, 32'd6, "R1 small");
    issue(2'b00, 32'hFFFFFFFF, 32'hFFFFFFFF, "R1 ones");
    issue(2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF, "R2 minus_one");
    issue(2'b01, 32'h80000000, 32'h80000000, "R10 ss_min");
    issue(2'b01, 32'h7FFFFFFF, 32'h80000000, "R2 max_min");
    issue(2'b10, 32'h80000000, 32'hFFFFFFFF, "R10 su_min");
    issue(2'b10, 32'hFFFFFFFF, 32'h00000002, "R3 neg_pos");
    issue(2'b11, 32'hFFFFFFFF, 32'hFFFFFFFF, "R4 ones");
    issue(2'b11, 32'h80000000, 32'h00000002, "R4 top_bit");

    // R9: busy right after accept, then restart in the completion cycle
    issue(2'b01, 32'h12345678, 32'h9ABCDEF0, "R2 mixed");
    check("R9 busy", 32'(busy_o), 32'd1);
    issue(2'b11, 32'h12345678, 32'h9ABCDEF0, "R9 back_to_back");

    // R6: start while busy must be dropped
    issue(2'b00, 32'h00010001, 32'h00020002, "R6 kept");
    start_i = 1'b1; op_i = 2'b11; src_a_i = 32'hDEADBEEF; src_b_i = 32'hCAFEF00D;
    @(negedge clk);
    start_i = 1'b0;
    check("R6 busy_during", 32'(busy_o), 32'd1);

    for (int i = 0; i < 120; i++) begin
      a = $urandom;
      b = $urandom;
      if (i % 7 == 0) a = 32'h80000000;
      if (i % 5 == 0) b = 32'hFFFFFFFF;
      case (i % 4)
        0: issue(2'b00, a, b, "R1 random");
        1: issue(2'b01, a, b, "R2 random");
        2: issue(2'b10, a, b, "R3 random");
        default: issue(2'b11, a, b, "R4 random");
      endcase
    end

    repeat (LAT + 4) @(negedge clk);
    check("R6 drained", 32'(sb_q.size()), 32'd0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule